// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block runs a short, high-priority group of analog-to-digital conversions. The group holds up to four ranks. Each rank takes its channel number from one of four 5-bit slots of a packed sequence word and has its own 12-bit offset. A start comes from one of two places. The first is a selected external trigger line, watched for a programmed edge. The second is the completion of a conversion in the regular group, when automatic chaining is enabled.

After a start, the sequencer walks the ranks over a simple request/done converter port. It subtracts each rank's offset from the raw sample and keeps the signed difference in that rank's result field. When the last rank finishes, it raises an end-of-group flag and a one-cycle interrupt pulse.

In discontinuous mode each start converts only the next rank. After the last rank the pointer wraps back to the first.

Top module: `inj_group_seq`

## Requirements
- R1: A configuration write with `cfgLen` outside 1..4 is rejected as a whole, and the previous length, sequence word, edge, source and mode bits stay in force. An offset write with `ofsRank` outside 1..4 changes no offset.
- R2: With length L, rank r (1..L) converts the channel held in `cfgSeq[5*(r+3-L) +: 5]`. Ranks are issued in ascending order, and that channel is presented on `convChan` while `convStart` is high.
- R3: Each rank's result is the 16-bit two's-complement value of (converted data − that rank's offset). It is stored at `resFlat[16*(r-1) +: 16]` for rank r, so a negative difference reads as a value of 0x8000 or above.
- R4: The 2-bit edge code selects when the trigger starts the group: 00 never, 01 on a rising edge, 10 on a falling edge, 11 on either edge.
- R5: The 4-bit source code picks `trigIn[src]` as the trigger. Transitions on every other trigger line start nothing.
- R6: With automatic chaining on, a one-cycle `regDone` pulse starts the whole group, and edges on the external trigger start nothing.
- R7: With discontinuous stepping on, each start converts exactly one rank, the next in order. The end-of-group flag rises only after rank L, and the following start converts rank 1 again.
- R8: After rank L completes, `eocFlag` is set and `eocIrq` is high for exactly one cycle. `eocFlag` stays set until a cycle with `eocClr` high. If a set and a clear fall in the same cycle, the set wins.
- R9: `convStart` is a one-cycle pulse per rank. The next pulse comes only after `convDone`. A trigger edge that arrives while a group is running is ignored, so a non-discontinuous group issues exactly L starts.
- R10: After reset, `busy`, `convStart`, `eocFlag` and `eocIrq` are low, all results read zero, and the length is 1 with triggering disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLen | input | 3 | Group length, 1..4 |
| cfgSeq | input | 20 | Four packed 5-bit channel slots |
| cfgEdge | input | 2 | Trigger edge code |
| cfgSrc | input | 4 | Trigger source index |
| cfgAuto | input | 1 | Start after each regular conversion |
| cfgDisc | input | 1 | Discontinuous stepping |
| ofsWe | input | 1 | Offset write strobe |
| ofsRank | input | 3 | Rank whose offset is written, 1..4 |
| ofsVal | input | 12 | Offset value |
| trigIn | input | 16 | Asynchronous trigger lines |
| regDone | input | 1 | Regular-group conversion completed (pulse) |
| convStart | output | 1 | Conversion request pulse |
| convChan | output | 5 | Channel for the current request |
| convDone | input | 1 | Converter finished (pulse) |
| convData | input | 12 | Raw converted sample, valid with convDone |
| resFlat | output | 64 | Four 16-bit signed rank results, rank 1 lowest |
| busy | output | 1 | A group or a single discontinuous step is running |
| eocFlag | output | 1 | End-of-group flag |
| eocIrq | output | 1 | One-cycle end-of-group pulse |
| eocClr | input | 1 | Clear the end-of-group flag |

## Verification
Two things can act on `eocFlag` in the same cycle: the end of the last rank sets it, and the write-one-to-clear input clears it. The bench holds `eocClr` high for the whole run of a group, which forces the set and the clear into one cycle. It then checks that the flag reads 1 in the cycle the interrupt pulses and falls to 0 in the cycle after. A second overlap arises when a trigger edge lands while a group is running. The bench toggles the trigger again in the middle of a sequence and counts converter requests to confirm that exactly L were issued.

// File: rtl/inj_group_pkg.sv
package inj_group_pkg;
  localparam int SLOTS  = 4;
  localparam int RANK_W = $clog2(SLOTS);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seqState_t;

  // Edge codes: bit 0 enables rising, bit 1 enables falling
  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  typedef struct packed {
    logic              store;
    logic [RANK_W-1:0] rank;
  } dpStrobe_t;
endpackage

// File: rtl/inj_group_dpath.sv
module inj_group_dpath
  import inj_group_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int RES_W    = 16,
  parameter int CHAN_W   = 5,
  parameter int NUM_TRIG = 16,
  localparam int SRC_W   = $clog2(NUM_TRIG),
  localparam int SEQ_W   = SLOTS * CHAN_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgLen,
  input  logic [SEQ_W-1:0]       cfgSeq,
  input  logic [1:0]             cfgEdge,
  input  logic [SRC_W-1:0]       cfgSrc,
  input  logic                   cfgAuto,
  input  logic                   cfgDisc,
  input  logic                   ofsWe,
  input  logic [2:0]             ofsRank,
  input  logic [DATA_W-1:0]      ofsVal,
  input  logic [NUM_TRIG-1:0]    trigIn,
  input  logic [DATA_W-1:0]      convData,
  input  dpStrobe_t              strobe,
  input  logic [RANK_W-1:0]      curRank,
  output logic [RANK_W-1:0]      lenM1,
  output logic                   autoEn,
  output logic                   discEn,
  output logic                   trigEvent,
  output logic [CHAN_W-1:0]      convChan,
  output logic [SLOTS*RES_W-1:0] resFlat
);
  logic [RANK_W-1:0] lenM1Q;
  logic [SEQ_W-1:0]  seqQ;
  logic [1:0]        edgeQ;
  logic [SRC_W-1:0]  srcQ;
  logic              autoQ, discQ;
  logic              lenOk;

  assign lenOk = (cfgLen >= 3'd1) && (cfgLen <= 3'(SLOTS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenM1Q <= '0;
      seqQ   <= '0;
      edgeQ  <= EDGE_OFF;
      srcQ   <= '0;
      autoQ  <= 1'b0;
      discQ  <= 1'b0;
    end else if (cfgWe && lenOk) begin
      lenM1Q <= RANK_W'(cfgLen - 3'd1);
      seqQ   <= cfgSeq;
      edgeQ  <= cfgEdge;
      srcQ   <= cfgSrc;
      autoQ  <= cfgAuto;
      discQ  <= cfgDisc;
    end
  end

  assign lenM1  = lenM1Q;
  assign autoEn = autoQ;
  assign discEn = discQ;

  // Select first, then synchronise the one chosen line
  logic [1:0] syncQ;
  logic       prevQ, riseEv, fallEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], trigIn[srcQ]};
      prevQ <= syncQ[1];
    end
  end

  assign riseEv    = syncQ[1] & ~prevQ;
  assign fallEv    = ~syncQ[1] & prevQ;
  assign trigEvent = (edgeQ[0] & riseEv) | (edgeQ[1] & fallEv);

  // Rank to slot: the group occupies the top L slots of the word
  logic [CHAN_W-1:0] chanSlot [SLOTS];
  logic [DATA_W-1:0] ofsQ     [SLOTS];
  logic [RES_W-1:0]  resQ     [SLOTS];
  logic [2:0]        slotIdx;
  logic [RES_W-1:0]  diff;

  assign slotIdx  = {1'b0, curRank} + 3'd3 - {1'b0, lenM1Q};
  assign convChan = chanSlot[slotIdx[RANK_W-1:0]];
  assign diff     = RES_W'(convData) - RES_W'(ofsQ[strobe.rank]);

  for (genvar g = 0; g < SLOTS; g++) begin : g_rank
    assign chanSlot[g] = seqQ[g*CHAN_W +: CHAN_W];
    assign resFlat[g*RES_W +: RES_W] = resQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ofsQ[g] <= '0;
        resQ[g] <= '0;
      end else begin
        if (ofsWe && (ofsRank == 3'(g + 1))) ofsQ[g] <= ofsVal;
        if (strobe.store && (strobe.rank == RANK_W'(g))) resQ[g] <= diff;
      end
    end
  end
endmodule

// File: rtl/inj_group_ctrl.sv
module inj_group_ctrl
  import inj_group_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigEvent,
  input  logic              regDone,
  input  logic              autoEn,
  input  logic              discEn,
  input  logic [RANK_W-1:0] lenM1,
  input  logic              convDone,
  input  logic              eocClr,
  output logic              convStart,
  output logic              busy,
  output logic [RANK_W-1:0] curRank,
  output dpStrobe_t         strobe,
  output logic              eocFlag,
  output logic              eocIrq
);
  seqState_t         stateQ;
  logic [RANK_W-1:0] rankQ;
  logic              eocFlagQ, eocIrqQ;
  logic              startReq, atLast, lastDone;

  assign startReq = autoEn ? regDone : trigEvent;
  assign atLast   = (rankQ >= lenM1);
  assign lastDone = (stateQ == ST_WAIT) && convDone && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      rankQ    <= '0;
      eocFlagQ <= 1'b0;
      eocIrqQ  <= 1'b0;
    end else begin
      eocIrqQ <= lastDone;
      if (lastDone)    eocFlagQ <= 1'b1;
      else if (eocClr) eocFlagQ <= 1'b0;

      case (stateQ)
        ST_IDLE: if (startReq) begin
          stateQ <= ST_REQ;
          if (!discEn || (rankQ > lenM1)) rankQ <= '0;
        end
        ST_REQ:  stateQ <= ST_WAIT;
        ST_WAIT: if (convDone) begin
          if (atLast) begin
            rankQ  <= '0;
            stateQ <= ST_IDLE;
          end else begin
            rankQ  <= rankQ + 1'b1;
            stateQ <= discEn ? ST_IDLE : ST_REQ;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign convStart    = (stateQ == ST_REQ);
  assign busy         = (stateQ != ST_IDLE);
  assign curRank      = rankQ;
  assign strobe.store = (stateQ == ST_WAIT) && convDone;
  assign strobe.rank  = rankQ;
  assign eocFlag      = eocFlagQ;
  assign eocIrq       = eocIrqQ;
endmodule

// File: rtl/inj_group_seq.sv
module inj_group_seq
  import inj_group_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int RES_W    = 16,
  parameter int CHAN_W   = 5,
  parameter int NUM_TRIG = 16,
  localparam int SRC_W   = $clog2(NUM_TRIG),
  localparam int SEQ_W   = SLOTS * CHAN_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [2:0]             cfgLen,
  input  logic [SEQ_W-1:0]       cfgSeq,
  input  logic [1:0]             cfgEdge,
  input  logic [SRC_W-1:0]       cfgSrc,
  input  logic                   cfgAuto,
  input  logic                   cfgDisc,
  input  logic                   ofsWe,
  input  logic [2:0]             ofsRank,
  input  logic [DATA_W-1:0]      ofsVal,
  input  logic [NUM_TRIG-1:0]    trigIn,
  input  logic                   regDone,
  output logic                   convStart,
  output logic [CHAN_W-1:0]      convChan,
  input  logic                   convDone,
  input  logic [DATA_W-1:0]      convData,
  output logic [SLOTS*RES_W-1:0] resFlat,
  output logic                   busy,
  output logic                   eocFlag,
  output logic                   eocIrq,
  input  logic                   eocClr
);
  dpStrobe_t         strobe;
  logic [RANK_W-1:0] curRank, lenM1;
  logic              autoEn, discEn, trigEvent;

  inj_group_dpath #(
    .DATA_W(DATA_W), .RES_W(RES_W), .CHAN_W(CHAN_W), .NUM_TRIG(NUM_TRIG)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgLen(cfgLen), .cfgSeq(cfgSeq), .cfgEdge(cfgEdge),
    .cfgSrc(cfgSrc), .cfgAuto(cfgAuto), .cfgDisc(cfgDisc),
    .ofsWe(ofsWe), .ofsRank(ofsRank), .ofsVal(ofsVal),
    .trigIn(trigIn), .convData(convData), .strobe(strobe), .curRank(curRank),
    .lenM1(lenM1), .autoEn(autoEn), .discEn(discEn), .trigEvent(trigEvent),
    .convChan(convChan), .resFlat(resFlat)
  );

  inj_group_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .trigEvent(trigEvent), .regDone(regDone), .autoEn(autoEn), .discEn(discEn),
    .lenM1(lenM1), .convDone(convDone), .eocClr(eocClr),
    .convStart(convStart), .busy(busy), .curRank(curRank), .strobe(strobe),
    .eocFlag(eocFlag), .eocIrq(eocIrq)
  );
endmodule

// File: rtl/inj_group_seq_chk.sv
module inj_group_seq_chk (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic busy,
  input logic eocFlag,
  input logic eocIrq,
  input logic eocClr
);
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_start_in_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> busy);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |=> !eocIrq);

  assert_irq_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> eocFlag);

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocFlag) |-> eocIrq);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (eocFlag && !eocClr) |=> eocFlag);
endmodule

bind inj_group_seq inj_group_seq_chk u_chk (.*);

// File: tb/inj_group_seq_tb.sv
`timescale 1ns/1ps
module inj_group_seq_tb;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgLen = 3'd1;
  logic [19:0] cfgSeq = '0;
  logic [1:0]  cfgEdge = 2'b00;
  logic [3:0]  cfgSrc = '0;
  logic        cfgAuto = 1'b0, cfgDisc = 1'b0;
  logic        ofsWe = 1'b0;
  logic [2:0]  ofsRank = '0;
  logic [11:0] ofsVal = '0;
  logic [15:0] trigIn = '0;
  logic        regDone = 1'b0;
  logic        convStart;
  logic [4:0]  convChan;
  logic        convDone = 1'b0;
  logic [11:0] convData = '0;
  logic [63:0] resFlat;
  logic        busy, eocFlag, eocIrq;
  logic        eocClr = 1'b0;

  int checks = 0, errors = 0;
  int startCnt = 0;
  logic [4:0] lastChan = '0, pendChan = '0;
  int pendCnt = 0;
  logic [11:0] ofsM [1:4];

  always #HALF clk = ~clk;

  inj_group_seq u_dut (.*);

  function automatic logic [11:0] fdata(input logic [4:0] ch);
    return 12'((int'(ch) * 131 + 50) & 12'hFFF);
  endfunction

  // Converter model: answers each request two cycles later
  always @(negedge clk) begin
    convDone = 1'b0;
    if (pendCnt != 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        convDone = 1'b1;
        convData = fdata(pendChan);
      end
    end
    if (convStart) begin
      startCnt++;
      lastChan = convChan;
      pendChan = convChan;
      pendCnt  = 2;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] chanOf(input int r, input int len, input logic [19:0] seq);
    return seq[5*(r+3-len) +: 5];
  endfunction

  function automatic logic [15:0] expRes(input int r, input int len, input logic [19:0] seq);
    return 16'(fdata(chanOf(r, len, seq))) - 16'(ofsM[r]);
  endfunction

  task automatic cfgWrite(input logic [2:0] len, input logic [19:0] seq, input logic [1:0] edg,
                          input logic [3:0] src, input logic au, input logic di);
    cfgLen = len; cfgSeq = seq; cfgEdge = edg; cfgSrc = src; cfgAuto = au; cfgDisc = di;
    cfgWe = 1'b1; tick(1); cfgWe = 1'b0;
  endtask

  task automatic configure(input logic [2:0] len, input logic [19:0] seq, input logic [1:0] edg,
                           input logic [3:0] src, input logic au, input logic di);
    cfgWrite(len, seq, 2'b00, src, 1'b0, 1'b0);
    trigIn = '0;
    tick(6);
    cfgWrite(len, seq, edg, src, au, di);
    tick(2);
  endtask

  task automatic writeOfs(input logic [2:0] r, input logic [11:0] v);
    ofsRank = r; ofsVal = v; ofsWe = 1'b1; tick(1); ofsWe = 1'b0;
  endtask

  task automatic fire(input logic [3:0] src, input logic [1:0] edg);
    if (edg == 2'b10) begin
      trigIn[src] = 1'b1; tick(6); trigIn[src] = 1'b0;
    end else begin
      trigIn[src] = ~trigIn[src];
    end
  endtask

  task automatic waitEoc(input string req);
    bit seen = 0;
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (eocIrq) begin seen = 1; break; end
    end
    chk(req, "end-of-group pulse seen", 32'(seen), 32'd1);
  endtask

  task automatic checkResults(input string req, input int len, input logic [19:0] seq);
    for (int r = 1; r <= len; r++)
      chk(req, $sformatf("result rank %0d", r), 32'(resFlat[16*(r-1) +: 16]), 32'(expRes(r, len, seq)));
  endtask

  task automatic clearEoc;
    eocClr = 1'b1; tick(1); eocClr = 1'b0;
  endtask

  // Table: len[28:26] seq[25:6] edge[5:4] src[3:0]
  localparam logic [28:0] VEC [6] = '{
    {3'd4, 20'hA5C31, 2'b01, 4'd0},
    {3'd1, 20'h7B2E4, 2'b10, 4'd9},
    {3'd2, 20'h3D190, 2'b11, 4'd15},
    {3'd3, 20'hF0E1D, 2'b01, 4'd6},
    {3'd4, 20'h18C6B, 2'b10, 4'd3},
    {3'd1, 20'hC9A57, 2'b11, 4'd12}
  };

  initial begin
    #(2*HALF*150000);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    tick(3);
    // R10: reset state
    chk("R10", "busy", 32'(busy), 0);
    chk("R10", "convStart", 32'(convStart), 0);
    chk("R10", "eocFlag", 32'(eocFlag), 0);
    chk("R10", "eocIrq", 32'(eocIrq), 0);
    chk("R10", "results low", resFlat[31:0], 0);
    chk("R10", "results high", resFlat[63:32], 0);
    rstN = 1'b1;
    tick(2);

    ofsM[1] = 12'd10; ofsM[2] = 12'd0; ofsM[3] = 12'd300; ofsM[4] = 12'hFFF;
    for (int r = 1; r <= 4; r++) writeOfs(3'(r), ofsM[r]);

    // Table walk: R2, R3, R4, R8, R9
    for (int v = 0; v < 6; v++) begin
      logic [2:0]  len = VEC[v][28:26];
      logic [19:0] seq = VEC[v][25:6];
      logic [1:0]  edg = VEC[v][5:4];
      logic [3:0]  src = VEC[v][3:0];
      configure(len, seq, edg, src, 1'b0, 1'b0);
      s0 = startCnt;
      fire(src, edg);
      waitEoc("R4");
      tick(10);
      chk("R9", "start count", 32'(startCnt - s0), 32'(len));
      chk("R2", "last channel", 32'(lastChan), 32'(chanOf(int'(len), int'(len), seq)));
      checkResults("R3", int'(len), seq);
      chk("R8", "flag held", 32'(eocFlag), 1);
      clearEoc();
      chk("R8", "flag cleared", 32'(eocFlag), 0);
    end

    // R1: rejected length and rank writes
    configure(3'd2, 20'h12345, 2'b01, 4'd0, 1'b0, 1'b0);
    cfgWrite(3'd5, 20'hFFFFF, 2'b00, 4'd7, 1'b1, 1'b1);
    cfgWrite(3'd0, 20'h00000, 2'b00, 4'd7, 1'b1, 1'b1);
    writeOfs(3'd0, 12'd777);
    writeOfs(3'd5, 12'd777);
    s0 = startCnt;
    fire(4'd0, 2'b01);
    waitEoc("R1");
    tick(10);
    chk("R1", "start count after bad writes", 32'(startCnt - s0), 2);
    checkResults("R1", 2, 20'h12345);
    clearEoc();

    // R4: edge code 00 never starts
    configure(3'd2, 20'h12345, 2'b00, 4'd0, 1'b0, 1'b0);
    s0 = startCnt;
    for (int k = 0; k < 4; k++) begin fire(4'd0, 2'b11); tick(8); end
    chk("R4", "no start when disabled", 32'(startCnt - s0), 0);

    // R5: other lines ignored, selected line fires
    configure(3'd1, 20'h9ABCD, 2'b01, 4'd5, 1'b0, 1'b0);
    s0 = startCnt;
    trigIn[3] = 1'b1; trigIn[6] = 1'b1; tick(15);
    chk("R5", "unselected lines", 32'(startCnt - s0), 0);
    fire(4'd5, 2'b01);
    waitEoc("R5");
    tick(5);
    chk("R5", "selected line", 32'(startCnt - s0), 1);
    clearEoc();

    // R9: edge during a running group ignored
    configure(3'd4, 20'h5A5A5, 2'b11, 4'd2, 1'b0, 1'b0);
    s0 = startCnt;
    fire(4'd2, 2'b11);
    tick(7);
    chk("R9", "busy mid-group", 32'(busy), 1);
    fire(4'd2, 2'b11);
    waitEoc("R9");
    tick(30);
    chk("R9", "no extra group", 32'(startCnt - s0), 4);
    checkResults("R9", 4, 20'h5A5A5);
    clearEoc();

    // R6: automatic chaining
    configure(3'd3, 20'h2468A, 2'b01, 4'd1, 1'b1, 1'b0);
    s0 = startCnt;
    fire(4'd1, 2'b01);
    tick(20);
    chk("R6", "external ignored", 32'(startCnt - s0), 0);
    regDone = 1'b1; tick(1); regDone = 1'b0;
    waitEoc("R6");
    tick(10);
    chk("R6", "chained count", 32'(startCnt - s0), 3);
    checkResults("R6", 3, 20'h2468A);
    clearEoc();

    // R7: discontinuous stepping and wrap
    configure(3'd3, 20'hB3C5E, 2'b11, 4'd4, 1'b0, 1'b1);
    s0 = startCnt;
    for (int k = 1; k <= 3; k++) begin
      fire(4'd4, 2'b11);
      tick(14);
      chk("R7", $sformatf("step %0d count", k), 32'(startCnt - s0), 32'(k));
      chk("R7", $sformatf("step %0d channel", k), 32'(lastChan), 32'(chanOf(k, 3, 20'hB3C5E)));
      chk("R7", $sformatf("step %0d flag", k), 32'(eocFlag), 32'(k == 3));
    end
    checkResults("R7", 3, 20'hB3C5E);
    clearEoc();
    fire(4'd4, 2'b11);
    tick(14);
    chk("R7", "wrap to rank 1", 32'(lastChan), 32'(chanOf(1, 3, 20'hB3C5E)));

    // R8: set and clear in the same cycle
    configure(3'd1, 20'h40000, 2'b01, 4'd0, 1'b0, 1'b0);
    eocClr = 1'b1;
    fire(4'd0, 2'b01);
    waitEoc("R8");
    chk("R8", "set wins over clear", 32'(eocFlag), 1);
    tick(1);
    chk("R8", "flag cleared next cycle", 32'(eocFlag), 0);
    chk("R8", "pulse one cycle", 32'(eocIrq), 0);
    eocClr = 1'b0;
    checkResults("R3", 1, 20'h40000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule